// File: doc/BRIEF.md
# Supply Fault Latch Sequencer

This block is the digital core of a multi-rail supply supervisor. Upstream comparators deliver synchronous under-voltage and over-voltage flags for each monitored rail, and the system supplies an active-low on/off request. The block drives a single fault-protect output. While that output is high the main converter is held off. While it is low the rails may deliver power.

The request is debounced on both edges before the block acts on it. When the rails are switched on, the output drops and a blanking window starts. During that window under-voltage flags are masked, so that rails which are still ramping do not trip the supervisor. Over-voltage checking stays live for the whole time the rails are enabled. Every rail flag must persist for a short qualification time before it counts as a fault.

A confirmed fault sets a latch that forces the output high and emits a one-cycle pulse, which a power-good stage can use to drop its own output at once. Only a debounced low-to-high transition of the request, or reset, clears the latch. A normal turn-off with no fault pending adds a further delay before the output rises. Every delay is counted in ticks of a shared prescaler, so each time constant is an integer parameter.

Top module: `supply_fault_seq`

## Requirements
- R1: During and after reset, `fault_prot_o` is 1 and `fault_pulse_o` is 0.
- R2: `on_req_ni` is active low. While it stays at 1, `fault_prot_o` stays at 1.
- R3: A level change on `on_req_ni`, in either direction, takes effect only after it has held for DEB_TICKS consecutive ticks. A shorter excursion leaves `fault_prot_o` unchanged.
- R4: Once the debounced request is low with no fault latched, `fault_prot_o` falls to 0 within one tick period plus two cycles after the debounce completes.
- R5: On a turn-off with no fault latched, `fault_prot_o` rises OFF_DLY_TICKS ticks after the debounce of the rising request completes, and not earlier.
- R6: For BLANK_TICKS ticks after each switch-on, `rail_uv_i` flags cannot produce a fault.
- R7: `rail_ov_i` flags are qualified during the blanking window as well.
- R8: A rail flag (bit i of `rail_uv_i` or `rail_ov_i` is rail i) must stay high for FILT_TICKS consecutive ticks before it is confirmed. Shorter pulses are ignored.
- R9: A confirmed fault drives `fault_prot_o` to 1 and keeps it there after the flag goes away, for as long as the request stays low.
- R10: `fault_pulse_o` is high for exactly one cycle, in the cycle where the latch sets, and `fault_prot_o` is 1 in that cycle.
- R11: The fault latch clears only on a debounced low-to-high transition of the request. In that case `fault_prot_o` stays at 1, with no low interval, and a later debounced low switches the rails on again.
- R12: While the rails are off, rail flags of both kinds are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| on_req_ni | input | 1 | Remote on/off request, 0 requests the rails on |
| rail_uv_i | input | NRAIL | Synchronous under-voltage flag for each rail |
| rail_ov_i | input | NRAIL | Synchronous over-voltage flag for each rail |
| fault_prot_o | output | 1 | 1 holds the main converter off |
| fault_pulse_o | output | 1 | One-cycle pulse when a fault latches |

## Verification
The assertions assume that the request and the rail flags are already synchronous to `clk_i` and change only between clock edges. They also assume that reset is held across several clock edges, so that past values start from reset state. The stimulus drives every input on the falling edge and holds reset low for several cycles at start-up. It keeps the flag pulses that are meant to be ignored at least one tick shorter than the qualifying time. Turn-on and turn-off timing is judged against windows one tick period wide, because the prescaler phase is not visible at the ports.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
  typedef enum logic [1:0] {
    SEQ_OFF  = 2'd0,
    SEQ_ON   = 2'd1,
    SEQ_STOP = 2'd2
  } seq_state_e;
endpackage

// File: rtl/sfs_tick_gen.sv
module sfs_tick_gen #(
  parameter int TICK_DIV = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CW = $clog2(TICK_DIV + 1);
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (cnt_q == LAST)  cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/sfs_req_debounce.sv
module sfs_req_debounce #(
  parameter int DEB_TICKS = 38000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic raw_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = $clog2(DEB_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(DEB_TICKS - 1);

  logic [CW-1:0] cnt_q;
  logic          level_q;
  logic          differ;

  assign differ = (raw_i != level_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      level_q <= 1'b1;  // off until proven otherwise
      rise_o  <= 1'b0;
      fall_o  <= 1'b0;
    end else begin
      rise_o <= 1'b0;
      fall_o <= 1'b0;
      if (!differ) begin
        cnt_q <= '0;
      end else if (tick_i) begin
        if (cnt_q == LAST) begin
          cnt_q   <= '0;
          level_q <= raw_i;
          rise_o  <= raw_i;
          fall_o  <= ~raw_i;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign level_o = level_q;

  assert_db_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_q != $past(level_q)) |-> ($past(tick_i) && ($past(raw_i) == level_q)));
endmodule

// File: rtl/sfs_flag_filter.sv
module sfs_flag_filter #(
  parameter int FILT_TICKS = 73
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic en_i,
  input  logic flag_i,
  output logic hit_o
);
  localparam int CW = $clog2(FILT_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(FILT_TICKS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      hit_o <= 1'b0;
    end else begin
      hit_o <= 1'b0;
      if (!en_i || !flag_i) begin
        cnt_q <= '0;
      end else if (tick_i) begin
        if (cnt_q == LAST) begin
          cnt_q <= '0;
          hit_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assert_hit_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> ($past(flag_i) && $past(en_i)));
endmodule

// File: rtl/supply_fault_seq.sv
module supply_fault_seq
  import sfs_pkg::*;
#(
  parameter int NRAIL         = 3,
  parameter int TICK_DIV      = 100,
  parameter int DEB_TICKS     = 38000,
  parameter int OFF_DLY_TICKS = 2300,
  parameter int BLANK_TICKS   = 75000,
  parameter int FILT_TICKS    = 73
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             on_req_ni,
  input  logic [NRAIL-1:0] rail_uv_i,
  input  logic [NRAIL-1:0] rail_ov_i,
  output logic             fault_prot_o,
  output logic             fault_pulse_o
);
  localparam int BW = $clog2(BLANK_TICKS + 1);
  localparam int SW = $clog2(OFF_DLY_TICKS + 1);
  localparam logic [BW-1:0] BLANK_END = BW'(BLANK_TICKS);
  localparam logic [SW-1:0] STOP_LAST = SW'(OFF_DLY_TICKS - 1);

  logic             tick;
  logic             req_level, req_rise, req_fall;
  seq_state_e       state_q;
  logic [BW-1:0]    blank_cnt_q;
  logic [SW-1:0]    stop_cnt_q;
  logic             blank;
  logic             rails_live;
  logic [NRAIL-1:0] uv_masked, uv_hit, ov_hit;
  logic             any_hit;
  logic             fault_q;

  sfs_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick)
  );

  sfs_req_debounce #(.DEB_TICKS(DEB_TICKS)) u_deb (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .raw_i(on_req_ni),
    .level_o(req_level), .rise_o(req_rise), .fall_o(req_fall)
  );

  assign rails_live = (state_q != SEQ_OFF);
  assign blank      = (blank_cnt_q != BLANK_END);
  assign uv_masked  = rail_uv_i & {NRAIL{~blank}};

  for (genvar g = 0; g < NRAIL; g++) begin : g_rail
    sfs_flag_filter #(.FILT_TICKS(FILT_TICKS)) u_uv (
      .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .en_i(rails_live),
      .flag_i(uv_masked[g]), .hit_o(uv_hit[g])
    );
    sfs_flag_filter #(.FILT_TICKS(FILT_TICKS)) u_ov (
      .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .en_i(rails_live),
      .flag_i(rail_ov_i[g]), .hit_o(ov_hit[g])
    );
  end

  assign any_hit = rails_live && (|uv_hit || |ov_hit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= SEQ_OFF;
      blank_cnt_q <= '0;
      stop_cnt_q  <= '0;
    end else begin
      if (tick && state_q == SEQ_ON && blank) blank_cnt_q <= blank_cnt_q + 1'b1;
      unique case (state_q)
        SEQ_OFF: if (req_fall) begin
          state_q     <= SEQ_ON;
          blank_cnt_q <= '0;
        end
        SEQ_ON: if (req_rise) begin
          // a latched fault skips the turn-off delay: output is already high
          state_q    <= fault_q ? SEQ_OFF : SEQ_STOP;
          stop_cnt_q <= '0;
        end
        SEQ_STOP: begin
          if (req_fall) begin
            state_q <= SEQ_ON;
          end else if (tick) begin
            if (stop_cnt_q == STOP_LAST) state_q <= SEQ_OFF;
            else                         stop_cnt_q <= stop_cnt_q + 1'b1;
          end
        end
        default: state_q <= SEQ_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_q       <= 1'b0;
      fault_pulse_o <= 1'b0;
    end else begin
      fault_pulse_o <= any_hit && !fault_q && !req_rise;
      if (req_rise)     fault_q <= 1'b0;
      else if (any_hit) fault_q <= 1'b1;
    end
  end

  assign fault_prot_o = (state_q == SEQ_OFF) || fault_q;

  assert_latch_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_q && !req_rise) |=> fault_q);
  assert_pulse_once_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_pulse_o |=> !fault_pulse_o);
  assert_pulse_prot_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_pulse_o |-> fault_prot_o);
  assert_uv_blank_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|uv_hit) |-> !$past(blank));
  assert_on_req_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fault_prot_o) |-> !req_level);
  assert_off_delay_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(fault_prot_o) && !fault_q) |-> ($past(state_q) == SEQ_STOP));
endmodule

// File: tb/sim_supply_fault_seq.sv
module sim_supply_fault_seq;
  localparam int NR = 3, B_DIV = 4, B_DEB = 6, B_OFF = 5, B_BLANK = 12, B_FILT = 3;
  localparam int FALL_LO = (B_DEB - 1) * B_DIV, FALL_HI = B_DEB * B_DIV + 3;
  localparam int OFFR_LO = (B_DEB + B_OFF - 2) * B_DIV, OFFR_HI = (B_DEB + B_OFF) * B_DIV + 4;
  localparam int FLT_LO = (B_FILT - 1) * B_DIV, FLT_HI = B_FILT * B_DIV + 3;
  localparam int EV_FALL = 0, EV_RISE = 1, EV_PULSE = 2;

  typedef struct { int kind; int base; int lo; int hi; string req; } exp_t;

  logic clk_i = 1'b0, rst_ni = 1'b0, on_req_ni = 1'b1;
  logic [NR-1:0] rail_uv_i = '0, rail_ov_i = '0;
  logic fault_prot_o, fault_pulse_o;

  int total = 0, bad = 0, cyc = 0;
  bit mon_on = 0, done = 0, prev_prot;
  exp_t exp_q[$];

  always #5 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  supply_fault_seq #(.NRAIL(NR), .TICK_DIV(B_DIV), .DEB_TICKS(B_DEB),
    .OFF_DLY_TICKS(B_OFF), .BLANK_TICKS(B_BLANK), .FILT_TICKS(B_FILT)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .on_req_ni(on_req_ni), .rail_uv_i(rail_uv_i),
    .rail_ov_i(rail_ov_i), .fault_prot_o(fault_prot_o), .fault_pulse_o(fault_pulse_o));

  task automatic chk(bit ok, string req, string what, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic push_exp(int kind, int lo, int hi, string req);
    exp_t e;
    e.kind = kind; e.base = cyc; e.lo = lo; e.hi = hi; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic got_ev(int kind);
    exp_t e;
    if (exp_q.size() == 0) begin
      chk(0, "R12", "unexpected output event kind", kind, -1);
      return;
    end
    e = exp_q.pop_front();
    chk(e.kind == kind, e.req, "event kind", kind, e.kind);
    chk((cyc - e.base) >= e.lo && (cyc - e.base) <= e.hi, e.req,
        "event delay (expected value is lower bound)", cyc - e.base, e.lo);
  endtask

  // monitor: compares observed output events with the scoreboard queue
  always @(negedge clk_i) begin
    if (mon_on) begin
      if (fault_pulse_o) got_ev(EV_PULSE);
      if (fault_prot_o != prev_prot) got_ev(fault_prot_o ? EV_RISE : EV_FALL);
      prev_prot = fault_prot_o;
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wait_prot(bit v);
    while (fault_prot_o != v) @(negedge clk_i);
  endtask

  task automatic turn_on(string req);
    on_req_ni = 1'b0;
    push_exp(EV_FALL, FALL_LO, FALL_HI, req);
  endtask

  initial begin
    wait_cyc(3);
    chk(fault_prot_o == 1'b1, "R1", "prot in reset", fault_prot_o, 1);
    rst_ni = 1'b1;
    wait_cyc(2);
    chk(fault_prot_o == 1'b1, "R1", "prot after reset", fault_prot_o, 1);
    chk(fault_pulse_o == 1'b0, "R1", "pulse after reset", fault_pulse_o, 0);
    prev_prot = fault_prot_o;
    mon_on = 1;

    // R2, R12: request off, all flags active
    rail_uv_i = '1; rail_ov_i = '1;
    wait_cyc(100);
    chk(fault_prot_o == 1'b1, "R2", "prot with request high", fault_prot_o, 1);
    rail_ov_i = '0;

    // R3: short low glitch on the request
    on_req_ni = 1'b0; wait_cyc((B_DEB - 3) * B_DIV); on_req_ni = 1'b1;
    wait_cyc(60);
    chk(fault_prot_o == 1'b1, "R3", "prot after low glitch", fault_prot_o, 1);

    // R4 turn-on with under-voltage still present; R6 blanking hides it
    turn_on("R4");
    wait_prot(1'b0);
    wait_cyc(B_BLANK * B_DIV - 3 * B_DIV);
    rail_uv_i = '0;
    wait_cyc(80);
    chk(fault_prot_o == 1'b0, "R6", "prot after blanked uv", fault_prot_o, 0);

    // R8: flag pulses shorter than the filter
    rail_ov_i[1] = 1'b1; rail_uv_i[0] = 1'b1;
    wait_cyc((B_FILT - 1) * B_DIV);
    rail_ov_i[1] = 1'b0; rail_uv_i[0] = 1'b0;
    wait_cyc(30);
    chk(fault_prot_o == 1'b0, "R8", "prot after short flags", fault_prot_o, 0);

    // R3: short high glitch while on
    on_req_ni = 1'b1; wait_cyc((B_DEB - 3) * B_DIV); on_req_ni = 1'b0;
    wait_cyc(60);
    chk(fault_prot_o == 1'b0, "R3", "prot after high glitch", fault_prot_o, 0);

    // R9, R10: persistent under-voltage after blanking
    rail_uv_i[2] = 1'b1;
    push_exp(EV_PULSE, FLT_LO, FLT_HI, "R10");
    push_exp(EV_RISE, FLT_LO, FLT_HI, "R9");
    wait_cyc(30);
    rail_uv_i[2] = 1'b0;
    wait_cyc(50);
    chk(fault_prot_o == 1'b1, "R9", "prot held after flag cleared", fault_prot_o, 1);

    // R11: request high clears latch, prot stays high (monitor sees no fall)
    on_req_ni = 1'b1;
    wait_cyc(80);
    chk(fault_prot_o == 1'b1, "R11", "prot after latch clear", fault_prot_o, 1);
    turn_on("R11");
    wait_prot(1'b0);

    // R7: over-voltage qualified during blanking, uv masked
    rail_ov_i[0] = 1'b1; rail_uv_i[1] = 1'b1;
    push_exp(EV_PULSE, FLT_LO, FLT_HI, "R7");
    push_exp(EV_RISE, FLT_LO, FLT_HI, "R7");
    wait_cyc(20);
    rail_ov_i[0] = 1'b0; rail_uv_i[1] = 1'b0;
    wait_cyc(20);
    chk(fault_prot_o == 1'b1, "R7", "prot after ov in blanking", fault_prot_o, 1);

    // clear, then on, then R5 normal turn-off with delay
    on_req_ni = 1'b1;
    wait_cyc(80);
    turn_on("R4");
    wait_prot(1'b0);
    wait_cyc(B_BLANK * B_DIV + 10);
    on_req_ni = 1'b1;
    push_exp(EV_RISE, OFFR_LO, OFFR_HI, "R5");
    wait_cyc(FALL_HI + 1);
    chk(fault_prot_o == 1'b0, "R5", "prot before off delay ends", fault_prot_o, 0);
    wait_prot(1'b1);

    // R12: flags while off
    rail_ov_i = '1; rail_uv_i = '1;
    wait_cyc(60);
    chk(fault_prot_o == 1'b1, "R12", "prot with flags while off", fault_prot_o, 1);
    chk(exp_q.size() == 0, "R10", "pending expected events", exp_q.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cyc >= 20000);
    if (!done) begin
      chk(0, "R1", "watchdog expired at cycle", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule